// File: doc/BRIEF.md
# Strip-Mined Vector Element Address Sequencer

This block produces the stream of element addresses for a single vector memory operation whose application length may exceed the hardware vector length. Software supplies a starting byte address, an addressing mode, a scalar byte stride, an application length and, for gathers, a stream of per-element byte offsets. The block cuts the length into hardware-sized pieces and emits one address per cycle under a valid/ready handshake. Each address carries the number of the interleaved memory bank it falls in, together with markers for the last element of a piece and the last element of the operation.

Strip-mining is done in hardware. The short remainder piece (length modulo the maximum vector length) goes out first, and full-length pieces follow. The pointer runs on without a break from one piece to the next, so each piece begins where the previous one ended. A one-cycle completion pulse follows the final accepted address.

The controller is a three-state machine. IDLE waits for a start pulse. The transition IDLE→RUN is taken on start with a nonzero length, and IDLE→FIN is taken on start with a zero length. RUN issues addresses, and RUN→FIN is taken when the final element is accepted. FIN lasts one cycle, raises the completion pulse and returns FIN→IDLE.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset the block is idle: `addr_valid_o`, `idx_ready_o`, `done_o` and `busy_o` are all 0.
- R2: The first piece holds n mod 64 elements, or 64 elements when that remainder is 0, and every later piece holds 64 elements. `piece_last_o` is 1 exactly on the last element of each piece.
- R3: Unit-stride mode gives element i the address base + 4·i. The count i runs over the whole operation, so a piece starts where the previous piece ended.
- R4: Constant-stride mode gives element i the address base + i·stride, where stride is a two's-complement byte stride. The sum wraps modulo 2^32.
- R5: Indexed mode gives each element the address base + offset, where the offset is the next word taken from the index stream. An index is consumed only when the address is accepted. In this mode `addr_valid_o` follows `idx_valid_i`, and `idx_ready_o` follows `addr_ready_i`.
- R6: The 2-bit mode field is encoded as follows: 0 is unit stride, 1 is constant stride, 2 is indexed, and 3 behaves as unit stride.
- R7: `bank_o` equals address bits [4:2], which is the word address modulo 8.
- R8: While `addr_valid_o` is 1 and `addr_ready_i` is 0, the address and element position hold. No element is skipped or repeated.
- R9: `op_last_o` marks the final element. `done_o` is 1 for exactly one cycle, in the cycle after that element is accepted. `busy_o` is 1 from the cycle after an accepted start through the `done_o` cycle.
- R10: A start pulse while `busy_o` is 1 is ignored. The running operation keeps its base, stride, mode and length.
- R11: A start with length 0 emits no address and raises `done_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| mode_i | input | 2 | Addressing mode (0 unit, 1 stride, 2 indexed, 3 unit) |
| base_i | input | 32 | Starting byte address |
| stride_i | input | 32 | Byte stride for mode 1, two's complement |
| total_i | input | 16 | Application length n in elements |
| idx_valid_i | input | 1 | Index stream word present |
| idx_data_i | input | 32 | Index stream byte offset |
| idx_ready_o | output | 1 | Index word consumed this cycle |
| addr_valid_o | output | 1 | Element address present |
| addr_ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | 32 | Element byte address |
| bank_o | output | 3 | Interleaved bank number of `addr_o` |
| piece_last_o | output | 1 | Last element of the current piece |
| op_last_o | output | 1 | Last element of the operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The two functions that can fall in the same cycle are the piece boundary and the operation end. When the length is an exact multiple of 64, or the final piece is full, `piece_last_o` and `op_last_o` are raised on the same element. The bench provokes this with lengths 64 and 130 and checks both flags, then checks that the completion pulse lands in the following cycle. Random back-pressure on `addr_ready_i` and gaps on `idx_valid_i` make the coinciding element wait for several cycles, and the reference model checks the held flags and address on every one of those cycles.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT     = 2'd0,
        MODE_STRIDE   = 2'd1,
        MODE_INDEX    = 2'd2,
        MODE_UNIT_ALT = 2'd3
    } vag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vag_state_e;

endpackage

// File: rtl/vag_seq_fsm.sv
module vag_seq_fsm
    import vag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       zero_len_i,
    input  logic       fire_i,
    input  logic       final_i,
    output logic       accept_o,
    output logic       run_o,
    output logic       busy_o,
    output logic       done_o
);

    vag_state_e state_q;
    vag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = zero_len_i ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (fire_i && final_i) begin
                    state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        accept_o = 1'b0;
        run_o    = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start_i;
            ST_RUN: begin
                run_o  = 1'b1;
                busy_o = 1'b1;
            end
            ST_FIN: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vag_piece_ctl.sv
module vag_piece_ctl #(
    parameter int LEN_W = 16,
    parameter int MVL   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] total_i,
    input  logic             fire_i,
    output logic             zero_o,
    output logic             piece_last_o,
    output logic             op_last_o
);

    localparam int REM_W = $clog2(MVL);
    localparam int CNT_W = REM_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(MVL);

    logic [LEN_W-1:0] remain_q;
    logic [CNT_W-1:0] elem_q;
    logic [CNT_W-1:0] plen_q;
    logic [CNT_W-1:0] first_len;
    logic [REM_W-1:0] rem_bits;

    assign rem_bits  = total_i[REM_W-1:0];
    assign first_len = (rem_bits == '0) ? FULL : {1'b0, rem_bits};
    assign zero_o    = (total_i == '0);

    assign piece_last_o = (elem_q == plen_q - CNT_W'(1));
    assign op_last_o    = (remain_q == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            elem_q   <= '0;
            plen_q   <= FULL;
        end else if (load_i) begin
            remain_q <= total_i;
            elem_q   <= '0;
            plen_q   <= first_len;
        end else if (fire_i) begin
            remain_q <= remain_q - LEN_W'(1);
            if (piece_last_o) begin
                elem_q <= '0;
                plen_q <= FULL;
            end else begin
                elem_q <= elem_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int NBANKS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              fire_i,
    input  logic [ADDR_W-1:0] idx_i,
    output logic              indexed_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] bank_o
);

    localparam int BSH    = $clog2(WORD_BYTES);
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;

    vag_mode_e         mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_UNIT;
            base_q <= '0;
            ptr_q  <= '0;
            step_q <= '0;
        end else if (load_i) begin
            mode_q <= vag_mode_e'(mode_i);
            base_q <= base_i;
            ptr_q  <= base_i;
            step_q <= (vag_mode_e'(mode_i) == MODE_STRIDE) ? stride_i
                                                            : ADDR_W'(WORD_BYTES);
        end else if (fire_i) begin
            ptr_q <= ptr_q + step_q;
        end
    end

    assign indexed_o = (mode_q == MODE_INDEX);
    assign addr_o    = indexed_o ? (base_q + idx_i) : ptr_q;

    generate
        if (NBANKS > 1) begin : g_banked
            assign bank_o = addr_o[BSH +: BANK_W];
        end else begin : g_single
            assign bank_o = '0;
        end
    endgenerate

endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int MVL        = 64,
    parameter int WORD_BYTES = 4,
    parameter int NBANKS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LEN_W-1:0]  total_i,
    input  logic              idx_valid_i,
    input  logic [ADDR_W-1:0] idx_data_i,
    output logic              idx_ready_o,
    output logic              addr_valid_o,
    input  logic              addr_ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] bank_o,
    output logic              piece_last_o,
    output logic              op_last_o,
    output logic              busy_o,
    output logic              done_o
);

    logic accept;
    logic run;
    logic fire;
    logic zero_len;
    logic indexed;
    logic plast_raw;
    logic olast_raw;

    vag_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .zero_len_i (zero_len),
        .fire_i     (fire),
        .final_i    (olast_raw),
        .accept_o   (accept),
        .run_o      (run),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    vag_piece_ctl #(
        .LEN_W (LEN_W),
        .MVL   (MVL)
    ) u_piece (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .total_i      (total_i),
        .fire_i       (fire),
        .zero_o       (zero_len),
        .piece_last_o (plast_raw),
        .op_last_o    (olast_raw)
    );

    vag_addr_gen #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .NBANKS     (NBANKS)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .mode_i    (mode_i),
        .base_i    (base_i),
        .stride_i  (stride_i),
        .fire_i    (fire),
        .idx_i     (idx_data_i),
        .indexed_o (indexed),
        .addr_o    (addr_o),
        .bank_o    (bank_o)
    );

    assign addr_valid_o = run && (!indexed || idx_valid_i);
    assign idx_ready_o  = run && indexed && addr_ready_i;
    assign fire         = addr_valid_o && addr_ready_i;
    assign piece_last_o = addr_valid_o && plast_raw;
    assign op_last_o    = addr_valid_o && olast_raw;

endmodule

// File: rtl/vag_checks.sv
module vag_checks #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [LEN_W-1:0]  total_i,
    input logic              idx_valid_i,
    input logic              addr_valid_o,
    input logic              addr_ready_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              piece_last_o,
    input logic              op_last_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              indexed
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && op_last_o) |=> done_o); // R9

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && total_i == '0) |=> (done_o && !addr_valid_o)); // R11

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !addr_ready_i && !indexed) |=> (addr_valid_o && $stable(addr_o))); // R8

    AST_FINAL_ENDS_PIECE: assert property (@(posedge clk) disable iff (!rst_n)
        op_last_o |-> piece_last_o); // R2

    AST_BUSY_START_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R10

    AST_INDEX_GATES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && indexed) |-> idx_valid_i); // R5

endmodule

bind vec_addr_seq vag_checks #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .total_i      (total_i),
    .idx_valid_i  (idx_valid_i),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .addr_o       (addr_o),
    .piece_last_o (piece_last_o),
    .op_last_o    (op_last_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .indexed      (indexed)
);

// File: tb/sim_vec_addr_seq.sv
`timescale 1ns/1ps
module sim_vec_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [31:0] base_i = '0;
    logic [31:0] stride_i = '0;
    logic [15:0] total_i = '0;
    logic        idx_valid_i = 1'b0;
    logic [31:0] idx_data_i = '0;
    logic        idx_ready_o;
    logic        addr_valid_o;
    logic        addr_ready_i = 1'b0;
    logic [31:0] addr_o;
    logic [2:0]  bank_o;
    logic        piece_last_o;
    logic        op_last_o;
    logic        busy_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] exp_addr[$];
    logic        exp_plast[$];
    logic        exp_olast[$];
    logic [31:0] idx_q[$];

    always #10 clk = ~clk;

    vec_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .base_i(base_i), .stride_i(stride_i), .total_i(total_i),
        .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i), .idx_ready_o(idx_ready_o),
        .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i), .addr_o(addr_o),
        .bank_o(bank_o), .piece_last_o(piece_last_o), .op_last_o(op_last_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic summary_and_quit();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            summary_and_quit();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Builds the expected element list from R2..R7 (mode 3 acts as unit: R6)
    task automatic build(input int mode, input logic [31:0] base, input logic [31:0] stride,
                         input int n);
        int len;
        int pos;
        logic [31:0] a;
        exp_addr.delete(); exp_plast.delete(); exp_olast.delete(); idx_q.delete();
        len = (n % 64 == 0) ? 64 : n % 64;
        pos = 0;
        for (int i = 0; i < n; i++) begin
            if (mode == 2) begin
                idx_q.push_back($urandom());
                a = base + idx_q[i];
            end else if (mode == 1) begin
                a = base + stride * i;
            end else begin
                a = base + 32'(4 * i);
            end
            exp_addr.push_back(a);
            exp_plast.push_back(pos == len - 1);
            exp_olast.push_back(i == n - 1);
            if (pos == len - 1) begin
                pos = 0;
                len = 64;
            end else begin
                pos = pos + 1;
            end
        end
    endtask

    task automatic run_op(input int mode, input logic [31:0] base, input logic [31:0] stride,
                          input int n, input int stall_pct, input bit poke_busy);
        bit pend_done;
        bit finished;
        int iter;
        build(mode, base, stride, n);
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(mode); base_i = base; stride_i = stride; total_i = 16'(n);
        addr_ready_i = 1'b1; idx_valid_i = 1'b0;
        #1;
        chk("R1 no valid while idle", {31'b0, addr_valid_o}, 32'd0);
        pend_done = (n == 0);
        finished = 1'b0;
        iter = 0;
        while (!finished) begin
            @(negedge clk);
            iter = iter + 1;
            start_i = 1'b0;
            if (poke_busy && iter == 3) begin
                start_i = 1'b1; mode_i = 2'd1; base_i = 32'hDEAD_0000;
                stride_i = 32'd100; total_i = 16'd1; // R10 must be ignored
            end
            addr_ready_i = (($urandom() % 100) >= 32'(stall_pct));
            idx_valid_i  = (mode == 2) && (idx_q.size() != 0) &&
                           (($urandom() % 100) >= 32'(stall_pct));
            idx_data_i   = (idx_q.size() != 0) ? idx_q[0] : $urandom();
            #1;
            chk("R9 done timing", {31'b0, done_o}, {31'b0, pend_done});
            if (pend_done) begin
                chk("R9 busy in done cycle", {31'b0, busy_o}, 32'd1);
                chk("R11 no address at done", {31'b0, addr_valid_o}, 32'd0);
                finished = 1'b1;
            end else begin
                chk("R9 busy while running", {31'b0, busy_o}, 32'd1);
                if (mode == 2) begin
                    chk("R5 valid follows index", {31'b0, addr_valid_o}, {31'b0, idx_valid_i});
                    chk("R5 index ready follows ready", {31'b0, idx_ready_o}, {31'b0, addr_ready_i});
                end else begin
                    chk("R8 valid held", {31'b0, addr_valid_o}, 32'd1);
                end
                if (addr_valid_o) begin
                    if (exp_addr.size() == 0) begin
                        chk("R9 extra element", 32'd1, 32'd0);
                    end else begin
                        chk(mode == 2 ? "R5 address" : (mode == 1 ? "R4 address" : "R3 R6 address"),
                            addr_o, exp_addr[0]);
                        chk("R7 bank", {29'b0, bank_o}, {29'b0, exp_addr[0][4:2]});
                        chk("R2 piece last", {31'b0, piece_last_o}, {31'b0, exp_plast[0]});
                        chk("R9 op last", {31'b0, op_last_o}, {31'b0, exp_olast[0]});
                        if (addr_ready_i) begin
                            pend_done = exp_olast[0];
                            void'(exp_addr.pop_front());
                            void'(exp_plast.pop_front());
                            void'(exp_olast.pop_front());
                            if (mode == 2) void'(idx_q.pop_front());
                        end
                    end
                end
            end
            if (iter > 20000) begin
                chk("R9 operation finishes", 32'd0, 32'd1);
                finished = 1'b1;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R9 idle after done", {31'b0, busy_o}, 32'd0);
        chk("R8 no element lost", 32'(exp_addr.size()), 32'd0);
        chk("R9 single pulse", {31'b0, done_o}, 32'd0);
    endtask

    initial begin
        #1;
        chk("R1 valid at reset", {31'b0, addr_valid_o}, 32'd0);
        chk("R1 done at reset", {31'b0, done_o}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 busy after reset", {31'b0, busy_o}, 32'd0);
        chk("R1 index ready after reset", {31'b0, idx_ready_o}, 32'd0);

        run_op(0, 32'h0000_1000, 32'd0, 5, 0, 1'b0);        // R3 short piece only
        run_op(0, 32'h0000_2004, 32'd0, 64, 30, 1'b0);      // R2 exact MVL: both flags coincide
        run_op(1, 32'h0001_0000, 32'd12, 130, 40, 1'b1);    // R2 R4 R10 pieces 2,64,64
        run_op(1, 32'h0000_0010, 32'hFFFF_FFF8, 70, 20, 1'b0); // R4 negative stride with wrap
        run_op(2, 32'h4000_0000, 32'd0, 67, 35, 1'b1);      // R5 gather with gaps
        run_op(3, 32'h0000_0300, 32'd999, 9, 50, 1'b0);     // R6 mode 3 as unit
        run_op(0, 32'h0000_0500, 32'd0, 0, 0, 1'b0);        // R11 zero length
        run_op(1, 32'h0000_0000, 32'd4, 128, 60, 1'b0);     // R8 heavy stall, two full pieces
        summary_and_quit();
    end

endmodule